// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard detection and operand forwarding decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, writeback). Branch equality is decided in the decode stage. The register file does not pass a value written in writeback to a decode read in the same cycle. Because of both, the unit must steer operands into the decode stage as well as into the execute stage.

The surrounding datapath supplies three things: the register numbers of each stage, the register-write and memory-read flags, and the branch flags of the decode stage. The equality result reported by the datapath is computed on the already-forwarded decode operands. The unit returns four mux selects, a stall and a flush. The mux selects cover the two decode comparator operands and the two execute ALU operands. The stall holds PC and the fetch/decode register and loads a do-nothing bubble into the decode/execute register. The flush squashes the instruction fetched on the fall-through path after a taken branch. Every output is a combinational function of the current inputs.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute-stage source that matches a writing memory-stage destination gets select 01 (memory-stage result). This holds even when writeback also matches.
- R2: An execute-stage source that matches only a writing writeback destination gets select 10. With no match the select is 00 (register value carried down the pipeline).
- R3: Register 0 is never forwarded: every select stays 00 for it. A producer writing register 0 never causes a stall.
- R4: A load in execute whose destination equals either decode source field asserts stall.
- R5: A decode branch that reads the destination of a writing non-load instruction in execute asserts stall. Once that producer reaches the memory stage, stall is low and the decode select is 01.
- R6: A decode branch that reads a load destination stalls while the load is in execute and again while it is in memory access, which gives two cycles in all. Once the load is in writeback, stall is low and the decode select is 10.
- R7: A decode source that matches a writing writeback destination gets decode select 10, so the register file never has to supply a value written in the same cycle. A load in the memory stage is never chosen as a decode source (select 01 is not used for it).
- R8: flush is high exactly when the decode instruction is a branch, the comparator reports taken, and stall is low.
- R9: When stall and a taken branch coincide, stall is high and flush is low.
- R10: With no register dependency on an execute-stage or memory-stage producer, stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch comparator result on forwarded operands |
| ex_rs | input | REG_W | First source register in execute |
| ex_rt | input | REG_W | Second source register in execute |
| ex_rd | input | REG_W | Destination register in execute |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register in memory access |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register in writeback |
| wb_regwrite | input | 1 | Writeback instruction writes a register |
| id_fwd_a | output | 2 | Decode operand A select: 00 register file, 01 memory stage, 10 writeback |
| id_fwd_b | output | 2 | Decode operand B select, same encoding |
| ex_fwd_a | output | 2 | Execute ALU operand A select: 00 pipeline register, 01 memory stage, 10 writeback |
| ex_fwd_b | output | 2 | Execute ALU operand B select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode, insert a bubble into decode/execute |
| flush | output | 1 | Squash the fetched fall-through instruction |

## Verification
The embedded properties check several rules on every cycle: a load in execute that feeds decode always stalls, flush never coincides with stall, a memory-stage select always points at a matching writing producer, and a decode select never names a load still in memory access. Only the bench's scenarios can show the multi-cycle orderings. These are the two-cycle stall of a branch behind a load, the one-cycle stall and later switch to the memory-stage path of a branch behind an ALU result, and the choice of the youngest producer when two stages match.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_branch,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output logic [1:0]       id_fwd_a,
  output logic [1:0]       id_fwd_b,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic             stall,
  output logic             flush
);

  localparam logic [1:0]       SEL_REG = 2'b00;
  localparam logic [1:0]       SEL_MEM = 2'b01;
  localparam logic [1:0]       SEL_WB  = 2'b10;
  localparam logic [REG_W-1:0] RZERO   = '0;

  function automatic logic [1:0] pick(input logic hit_mem, input logic hit_wb);
    return hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_REG);
  endfunction

  logic ex_live, mem_live, mem_alu, wb_live;
  assign ex_live  = ex_regwrite  && (ex_rd  != RZERO);
  assign mem_live = mem_regwrite && (mem_rd != RZERO);
  assign mem_alu  = mem_live && !mem_memread;
  assign wb_live  = wb_regwrite  && (wb_rd  != RZERO);

  assign ex_fwd_a = pick(mem_live && mem_rd == ex_rs, wb_live && wb_rd == ex_rs);
  assign ex_fwd_b = pick(mem_live && mem_rd == ex_rt, wb_live && wb_rd == ex_rt);
  assign id_fwd_a = pick(mem_alu && mem_rd == id_rs, wb_live && wb_rd == id_rs);
  assign id_fwd_b = pick(mem_alu && mem_rd == id_rt, wb_live && wb_rd == id_rt);

  logic ex_dep, mem_dep, load_use, br_ex, br_mem;
  assign ex_dep   = ex_live && (ex_rd == id_rs || ex_rd == id_rt);
  assign mem_dep  = mem_live && (mem_rd == id_rs || mem_rd == id_rt);
  assign load_use = ex_memread && ex_dep;
  assign br_ex    = id_branch && ex_dep;
  assign br_mem   = id_branch && mem_memread && mem_dep;

  assign stall = load_use || br_ex || br_mem;
  assign flush = id_branch && id_br_taken && !stall;

  assert_load_use_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_memread && ex_regwrite && ex_rd != RZERO && (ex_rd == id_rs || ex_rd == id_rt)) |-> stall);

  assert_branch_alu_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && ex_regwrite && ex_rd != RZERO && ex_rd == id_rs) |-> stall);

  assert_branch_load_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && mem_memread && mem_regwrite && mem_rd != RZERO && mem_rd == id_rt) |-> stall);

  assert_exmem_sel_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == SEL_MEM) |-> (mem_regwrite && mem_rd == ex_rs && ex_rs != RZERO));

  assert_zero_not_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == RZERO) |-> (ex_fwd_b == SEL_REG));

  assert_id_no_load_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_memread) |-> (id_fwd_a != SEL_MEM && id_fwd_b != SEL_MEM));

  assert_flush_needs_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (id_branch && id_br_taken));

  assert_stall_beats_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !flush);

endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_branch, id_br_taken, ex_regwrite, ex_memread;
  logic mem_regwrite, mem_memread, wb_regwrite;
  logic [1:0] id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b;
  logic stall, flush;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_fwd_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .id_branch(id_branch), .id_br_taken(id_br_taken),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .ex_regwrite(ex_regwrite), .ex_memread(ex_memread),
    .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
    .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b), .ex_fwd_a(ex_fwd_a),
    .ex_fwd_b(ex_fwd_b), .stall(stall), .flush(flush));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs = 0; id_rt = 0; id_branch = 0; id_br_taken = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_regwrite = 0; ex_memread = 0;
    mem_rd = 0; mem_regwrite = 0; mem_memread = 0;
    wb_rd = 0; wb_regwrite = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    idle(); step();
    chk("R10 reset stall", stall, 0);
    chk("R8 reset flush", flush, 0);
    chk("R2 reset ex_fwd_a", ex_fwd_a, 0);
    chk("R7 reset id_fwd_a", id_fwd_a, 0);
  endtask

  task automatic t_ex_forward();
    idle();
    ex_rs = 4; ex_rt = 6;
    mem_rd = 4; mem_regwrite = 1;
    wb_rd = 4; wb_regwrite = 1;
    step();
    chk("R1 mem over wb", ex_fwd_a, 1);
    chk("R2 no match b", ex_fwd_b, 0);
    wb_rd = 6; step();
    chk("R2 wb only b", ex_fwd_b, 2);
    mem_regwrite = 0; step();
    chk("R1 mem not writing", ex_fwd_a, 0);
  endtask

  task automatic t_zero();
    idle();
    ex_rs = 0; ex_rt = 0; mem_rd = 0; mem_regwrite = 1;
    wb_rd = 0; wb_regwrite = 1;
    id_rs = 0; id_rt = 0; id_branch = 1;
    ex_rd = 0; ex_regwrite = 1; ex_memread = 1;
    step();
    chk("R3 zero ex_fwd_a", ex_fwd_a, 0);
    chk("R3 zero id_fwd_b", id_fwd_b, 0);
    chk("R3 zero stall", stall, 0);
  endtask

  task automatic t_load_use();
    idle();
    id_rs = 3; id_rt = 9;
    ex_rd = 9; ex_regwrite = 1; ex_memread = 1;
    step();
    chk("R4 load-use rt", stall, 1);
    ex_memread = 0; step();
    chk("R10 alu in ex non-branch", stall, 0);
  endtask

  task automatic t_branch_alu();
    idle();
    id_branch = 1; id_rs = 4; id_rt = 3;
    ex_rd = 4; ex_regwrite = 1;
    step();
    chk("R5 branch alu stall", stall, 1);
    ex_rd = 0; ex_regwrite = 0; mem_rd = 4; mem_regwrite = 1;
    step();
    chk("R5 after stall no stall", stall, 0);
    chk("R5 id select mem", id_fwd_a, 1);
  endtask

  task automatic t_branch_load();
    idle();
    id_branch = 1; id_rs = 1; id_rt = 4;
    ex_rd = 1; ex_regwrite = 1; ex_memread = 1;
    step();
    chk("R6 load in ex stall", stall, 1);
    ex_rd = 0; ex_regwrite = 0; ex_memread = 0;
    mem_rd = 1; mem_regwrite = 1; mem_memread = 1;
    step();
    chk("R6 load in mem stall", stall, 1);
    chk("R7 load in mem not selected", id_fwd_a, 0);
    mem_rd = 0; mem_regwrite = 0; mem_memread = 0;
    wb_rd = 1; wb_regwrite = 1;
    step();
    chk("R6 load in wb no stall", stall, 0);
    chk("R6 id select wb", id_fwd_a, 2);
  endtask

  task automatic t_wb_decode();
    idle();
    id_rs = 7; id_rt = 8; wb_rd = 8; wb_regwrite = 1;
    step();
    chk("R7 wb to decode b", id_fwd_b, 2);
    chk("R7 decode a untouched", id_fwd_a, 0);
  endtask

  task automatic t_flush();
    idle();
    id_branch = 1; id_br_taken = 1; id_rs = 5; id_rt = 6;
    step();
    chk("R8 taken flush", flush, 1);
    id_br_taken = 0; step();
    chk("R8 not taken", flush, 0);
    id_branch = 0; id_br_taken = 1; step();
    chk("R8 no branch", flush, 0);
  endtask

  task automatic t_stall_prec();
    idle();
    id_branch = 1; id_br_taken = 1; id_rs = 2; id_rt = 5;
    ex_rd = 5; ex_regwrite = 1;
    step();
    chk("R9 stall high", stall, 1);
    chk("R9 flush held", flush, 0);
  endtask

  task automatic t_independent();
    idle();
    id_branch = 1; id_rs = 10; id_rt = 11;
    ex_rd = 12; ex_regwrite = 1; ex_memread = 1;
    mem_rd = 13; mem_regwrite = 1; mem_memread = 1;
    step();
    chk("R10 independent", stall, 0);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ex_forward();
    t_zero();
    t_load_use();
    t_branch_alu();
    t_branch_load();
    t_wb_decode();
    t_flush();
    t_stall_prec();
    t_independent();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule